// File: doc/BRIEF.md
# Auto-Request Block Copy DMA Channel

This block is one DMA channel that copies a block of items from a source region to a destination region over a simple request/ready memory port. Software first writes a packed 32-bit control word and two end pointers while the channel is idle. It then sets the channel enable and pulses a software request. In auto-request mode that one request carries the whole block through to the end. The channel gives the shared bus back at regular intervals that the control word sets, so that other masters can get in. A single grant input stands for the result of that outside arbitration.

The control word holds these fields:

- **Bits 31:30** hold the destination increment code and **bits 29:28** the destination size code.
- **Bits 27:26** hold the source increment code and **bits 25:24** the source size code.
- **Bits 17:14** hold an arbitration exponent k.
- **Bits 13:4** hold the item count minus one.
- **Bits 2:0** hold the mode.

The other bits are stored and returned unchanged.

The current address of each side is its end pointer minus the remaining count times the step. For this purpose the remaining count is the value in bits 13:4, and that field counts down as items complete. When the last item has been written, the channel does three things in the same clock edge:

- It zeroes the mode field so that software can poll for completion.
- It clears the enable.
- It raises a one-cycle done pulse.

Top module: `dma_autocopy`

## Requirements
- R1: After reset, `en_status`, `done`, `err`, `bus_req` and `mem_req` are low and `ctl_out` is zero.
- R2: With `en_status` high and mode bits 2:0 equal to 2, a one-cycle `sw_req` makes `bus_req` high in the following cycle.
- R3: A `sw_req` that arrives while `en_status` is low, or while the mode field is not 2, has no effect: `bus_req` stays low and `ctl_out` keeps its value.
- R4: A started transfer moves exactly (bits 13:4)+1 items. Each item is one read followed by one write. After each completed write, bits 13:4 of `ctl_out` drop by one, down to zero.
- R5: The address for each side is the end pointer minus (bits 13:4) × step. The step is 1, 2 or 4 bytes for increment code 0, 1 or 2. With increment code 3 the address is fixed at the end pointer. `mem_size` carries that side's size code.
- R6: The data written for each item equals the data returned by its preceding read.
- R7: `bus_req` rises before the first access, and no access is made until `bus_gnt` has been seen. Each time 2^k items have completed, where k is bits 17:14, and more items remain, `bus_req` drops for exactly one cycle. The channel then waits for `bus_gnt` again.
- R8: A memory access holds its request, direction and address until `mem_ready` is high.
- R9: In the cycle after the last write handshake, the following hold:
  - `done` is high for one cycle.
  - `en_status` is low.
  - Bits 2:0 and 13:4 of `ctl_out` are zero.
  - All other bits of `ctl_out` are unchanged.
- R10: An `en_set` in the same cycle as the last write handshake wins, so `en_status` stays high.
- R11: A start with a source or destination size code of 3 raises `err` in the next cycle, leaves `en_status` high and makes no bus request. The next `cfg_load` clears `err`.
- R12: A `cfg_load` while a transfer is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load control word and end pointers (idle only) |
| cfg_ctl | input | 32 | Control word |
| cfg_src_end | input | AW | Source end pointer |
| cfg_dst_end | input | AW | Destination end pointer |
| en_set | input | 1 | Set channel enable |
| sw_req | input | 1 | Software transfer request |
| en_status | output | 1 | Channel enable status |
| err | output | 1 | Invalid size code seen at start |
| done | output | 1 | One-cycle completion pulse |
| ctl_out | output | 32 | Stored control word |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant from the outside arbiter |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data |
| mem_ready | input | 1 | Access accepted |

## Verification
Completion clears the enable. In the same cycle, software may be setting the enable again, and the two updates fall on one register. To provoke this, the bench drives `en_set` in exactly the cycle in which the final write sees `mem_ready`. It then judges that `en_status` stays high while `done` still pulses and the mode field still clears.

An arbitration boundary can also fall on the last item, for example with a single item or with k = 0. The reference model checks on every cycle that in this case `bus_req` drops only because the transfer has ended, with no release cycle.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_RD,
    ST_WR,
    ST_REL
  } dmac_state_e;

  // Packed control word, most significant field first (bit 31 down to 0).
  typedef struct packed {
    logic [1:0] dst_inc;
    logic [1:0] dst_sz;
    logic [1:0] src_inc;
    logic [1:0] src_sz;
    logic [1:0] rsv_hi;
    logic       dst_priv;
    logic [1:0] rsv_lo;
    logic       src_priv;
    logic [3:0] arb_exp;
    logic [9:0] cnt_m1;
    logic       burst_nxt;
    logic [2:0] mode;
  } dmac_ctl_t;

  localparam logic [2:0] MODE_STOP = 3'd0;
  localparam logic [2:0] MODE_AUTO = 3'd2;
  localparam logic [1:0] INC_NONE  = 2'd3;
  localparam logic [1:0] SZ_BAD    = 2'd3;

endpackage

// File: rtl/dmac_rst_sync.sv
module dmac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/dmac_addr_gen.sv
module dmac_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 10
) (
  input  logic [AW-1:0] end_ptr,
  input  logic [1:0]    inc,
  input  logic [CW-1:0] cnt_m1,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] span;

  always_comb begin
    span = '0;
    if (inc != dmac_pkg::INC_NONE) span = AW'(cnt_m1) << inc;
    addr = end_ptr - span;
  end

endmodule

// File: rtl/dmac_beat_cnt.sv
module dmac_beat_cnt #(
  parameter int BW = 16,
  parameter int KW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [KW-1:0] exp_k,
  output logic          at_edge
);

  logic [BW-1:0] cnt_q, cnt_d, limit;
  logic          cnt_en;

  always_comb begin
    limit   = (BW'(1) << exp_k) - BW'(1);
    at_edge = (cnt_q == limit);
    cnt_en  = clr | step;
    cnt_d   = cnt_q;
    if (clr)          cnt_d = '0;
    else if (at_edge) cnt_d = '0;
    else              cnt_d = cnt_q + BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/dma_autocopy.sv
module dma_autocopy #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [31:0]   cfg_ctl,
  input  logic [AW-1:0] cfg_src_end,
  input  logic [AW-1:0] cfg_dst_end,
  input  logic          en_set,
  input  logic          sw_req,
  output logic          en_status,
  output logic          err,
  output logic          done,
  output logic [31:0]   ctl_out,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready
);
  import dmac_pkg::*;

  localparam int CW = 10;

  logic              rst_i_n;
  dmac_state_e       st_q, st_d;
  dmac_ctl_t         ctl_q, ctl_d;
  logic [AW-1:0]     src_q, dst_q, src_addr, dst_addr;
  logic [DW-1:0]     data_q;
  logic              en_q, en_d, err_q, err_d, done_q;
  logic              idle, go, bad, rd_hs, wr_hs, last, finish, at_edge;
  logic              ld_en, ctl_en;

  dmac_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  dmac_addr_gen #(.AW(AW), .CW(CW)) u_src_addr (
    .end_ptr(src_q), .inc(ctl_q.src_inc), .cnt_m1(ctl_q.cnt_m1), .addr(src_addr));

  dmac_addr_gen #(.AW(AW), .CW(CW)) u_dst_addr (
    .end_ptr(dst_q), .inc(ctl_q.dst_inc), .cnt_m1(ctl_q.cnt_m1), .addr(dst_addr));

  dmac_beat_cnt #(.BW(BW), .KW(4)) u_beats (
    .clk(clk), .rst_n(rst_i_n), .clr(go), .step(wr_hs),
    .exp_k(ctl_q.arb_exp), .at_edge(at_edge));

  // Decode
  always_comb begin
    idle   = (st_q == ST_IDLE);
    go     = idle && sw_req && en_q && (ctl_q.mode == MODE_AUTO);
    bad    = (ctl_q.src_sz == SZ_BAD) || (ctl_q.dst_sz == SZ_BAD);
    rd_hs  = (st_q == ST_RD) && mem_ready;
    wr_hs  = (st_q == ST_WR) && mem_ready;
    last   = (ctl_q.cnt_m1 == '0);
    finish = wr_hs && last;
    ld_en  = idle && cfg_load;
    ctl_en = ld_en || wr_hs;
  end

  // Next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (go && !bad) st_d = ST_ARB;
      ST_ARB:  if (bus_gnt)    st_d = ST_RD;
      ST_RD:   if (mem_ready)  st_d = ST_WR;
      ST_WR:   if (mem_ready)  st_d = last ? ST_IDLE : (at_edge ? ST_REL : ST_RD);
      ST_REL:                  st_d = ST_ARB;
      default:                 st_d = ST_IDLE;
    endcase
  end

  // Next control word, enable and error
  always_comb begin
    ctl_d = ctl_q;
    if (ld_en)      ctl_d = dmac_ctl_t'(cfg_ctl);
    else if (finish) ctl_d.mode = MODE_STOP;
    else if (wr_hs)  ctl_d.cnt_m1 = ctl_q.cnt_m1 - CW'(1);

    en_d = en_q;
    if (en_set)      en_d = 1'b1;
    else if (finish) en_d = 1'b0;

    err_d = err_q;
    if (ld_en)           err_d = 1'b0;
    else if (go && bad)  err_d = 1'b1;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_IDLE;
      ctl_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      data_q <= '0;
      en_q   <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      en_q   <= en_d;
      err_q  <= err_d;
      done_q <= finish;
      if (ctl_en) ctl_q <= ctl_d;
      if (ld_en) begin
        src_q <= cfg_src_end;
        dst_q <= cfg_dst_end;
      end
      if (rd_hs) data_q <= mem_rdata;
    end
  end

  // Outputs
  assign en_status = en_q;
  assign err       = err_q;
  assign done      = done_q;
  assign ctl_out   = ctl_q;
  assign bus_req   = (st_q == ST_ARB) || (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_req   = (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_we    = (st_q == ST_WR);
  assign mem_addr  = mem_we ? dst_addr : src_addr;
  assign mem_size  = mem_we ? ctl_q.dst_sz : ctl_q.src_sz;
  assign mem_wdata = data_q;

endmodule

// File: rtl/dmac_checker.sv
module dmac_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_req,
  input logic          en_set,
  input logic          en_status,
  input logic          err,
  input logic          done,
  input logic [31:0]   ctl_out,
  input logic          bus_req,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ready
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ctl_out[2:0] == 3'd0 && ctl_out[13:4] == 10'd0)); // R9

  AST_ACCESS_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> bus_req); // R7

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr))); // R8

  AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !bus_req); // R11

  AST_IGNORED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && !en_status && !bus_req) |=> !bus_req); // R3

  AST_EN_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    en_set |=> en_status); // R10

endmodule

bind dma_autocopy dmac_checker #(.AW(AW)) i_dmac_checker (
  .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .en_set(en_set),
  .en_status(en_status), .err(err), .done(done), .ctl_out(ctl_out),
  .bus_req(bus_req), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_ready(mem_ready));

// File: tb/test_dma_autocopy.sv
`timescale 1ns/100ps
module test_dma_autocopy;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load = 1'b0;
  logic [31:0] cfg_ctl = '0, cfg_src_end = '0, cfg_dst_end = '0;
  logic        en_set, en_set_t = 1'b0, en_set_a = 1'b0;
  logic        sw_req = 1'b0;
  logic        en_status, err, done, bus_req, mem_req, mem_we;
  logic [31:0] ctl_out, mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic        bus_gnt = 1'b0, mem_ready = 1'b0;

  int checks = 0, fails = 0, wr_cnt = 0;
  int gnt_pct = 100, rdy_pct = 100;
  bit arm_end = 0, end_hit = 0, finished = 0;

  always #2.5 clk = ~clk;
  assign en_set = en_set_t | en_set_a;

  function automatic logic [31:0] rd_fn(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, ~a[31:16]};
  endfunction
  assign mem_rdata = rd_fn(mem_addr);

  dma_autocopy i_dma_autocopy (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_ctl(cfg_ctl),
    .cfg_src_end(cfg_src_end), .cfg_dst_end(cfg_dst_end), .en_set(en_set),
    .sw_req(sw_req), .en_status(en_status), .err(err), .done(done),
    .ctl_out(ctl_out), .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready));

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] e, input logic [1:0] inc, input int n);
    if (inc == 2'd3) return e;
    return e - 32'(n * (1 << inc));
  endfunction

  function automatic logic [31:0] mk(input int dinc, dsz, sinc, ssz, k, nm1, mode);
    return {dinc[1:0], dsz[1:0], sinc[1:0], ssz[1:0], 2'b01, 1'b1, 2'b10, 1'b0,
            k[3:0], nm1[9:0], 1'b1, mode[2:0]};
  endfunction

  // Behavioural reference model: 0 idle, 1 waiting grant, 2 read, 3 write, 4 release
  int          m_st, m_items;
  logic [31:0] m_ctl, m_src, m_dst, m_data;
  bit          m_en, m_err, m_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_items = 0; m_ctl = 0; m_src = 0; m_dst = 0; m_data = 0;
      m_en = 0; m_err = 0; m_done = 0;
    end else begin
      bit fin;
      int left;
      fin = 0;
      left = int'(m_ctl[13:4]);
      m_done = 0;
      if (mem_req && mem_we && mem_ready) wr_cnt++;
      case (m_st)
        0: begin
          if (sw_req && m_en && m_ctl[2:0] == 3'd2) begin
            if (m_ctl[29:28] == 2'd3 || m_ctl[25:24] == 2'd3) m_err = 1;
            else begin m_st = 1; m_items = 0; end
          end
          if (cfg_load) begin
            m_ctl = cfg_ctl; m_src = cfg_src_end; m_dst = cfg_dst_end; m_err = 0;
          end
        end
        1: if (bus_gnt) m_st = 2;
        2: if (mem_ready) begin
             m_data = rd_fn(exp_addr(m_src, m_ctl[27:26], left));
             m_st = 3;
           end
        3: if (mem_ready) begin
             m_items++;
             if (left == 0) begin
               m_ctl[2:0] = 3'd0; m_done = 1; fin = 1; m_st = 0;
             end else begin
               m_ctl[13:4] = 10'(left - 1);
               m_st = (m_items % (1 << m_ctl[17:14]) == 0) ? 4 : 2;
             end
           end
        default: m_st = 1;
      endcase
      if (en_set) m_en = 1;
      else if (fin) m_en = 0;
    end
  end

  // Cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk_eq("R7 bus_req", 32'(bus_req), 32'(m_st == 1 || m_st == 2 || m_st == 3));
      chk_eq("R4 mem_req", 32'(mem_req), 32'(m_st == 2 || m_st == 3));
      chk_eq("R8 mem_we", 32'(mem_we), 32'(m_st == 3));
      if (m_st == 2) begin
        chk_eq("R5 read address", mem_addr, exp_addr(m_src, m_ctl[27:26], int'(m_ctl[13:4])));
        chk_eq("R5 read size", 32'(mem_size), 32'(m_ctl[25:24]));
      end
      if (m_st == 3) begin
        chk_eq("R5 write address", mem_addr, exp_addr(m_dst, m_ctl[31:30], int'(m_ctl[13:4])));
        chk_eq("R5 write size", 32'(mem_size), 32'(m_ctl[29:28]));
        chk_eq("R6 write data", mem_wdata, m_data);
      end
      chk_eq("R9 done", 32'(done), 32'(m_done));
      chk_eq("R10 enable", 32'(en_status), 32'(m_en));
      chk_eq("R11 err", 32'(err), 32'(m_err));
      chk_eq("R4 ctl_out", ctl_out, m_ctl);
    end
  end

  // Grant / ready driver and end-of-transfer enable collision
  always @(negedge clk) begin
    bus_gnt   = ($urandom_range(0, 99) < gnt_pct);
    mem_ready = ($urandom_range(0, 99) < rdy_pct);
    en_set_a  = arm_end && m_st == 3 && m_ctl[13:4] == 10'd0 && mem_ready;
    if (en_set_a) begin arm_end = 0; end_hit = 1; end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [31:0] c, input logic [31:0] s, input logic [31:0] d);
    @(negedge clk); cfg_load = 1; cfg_ctl = c; cfg_src_end = s; cfg_dst_end = d;
    @(negedge clk); cfg_load = 0;
  endtask

  task automatic enable();
    @(negedge clk); en_set_t = 1;
    @(negedge clk); en_set_t = 0;
  endtask

  task automatic request();
    @(negedge clk); sw_req = 1;
    @(negedge clk); sw_req = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) chk_eq("R9 completion timeout", 0, 1);
  endtask

  task automatic run(input logic [31:0] c, input logic [31:0] s, input logic [31:0] d);
    load(c, s, d);
    enable();
    wr_cnt = 0;
    request();
    chk_eq("R2 bus_req after request", 32'(bus_req), 1);
    wait_done();
    chk_eq("R4 item count", wr_cnt, 32'(c[13:4]) + 1);
    chk_eq("R9 word after completion", ctl_out, {c[31:14], 10'd0, c[3], 3'd0});
  endtask

  initial begin
    rst_n = 0;
    cyc(4);
    rst_n = 1;
    cyc(4);
    chk_eq("R1 reset en_status", 32'(en_status), 0);
    chk_eq("R1 reset done", 32'(done), 0);
    chk_eq("R1 reset err", 32'(err), 0);
    chk_eq("R1 reset bus_req", 32'(bus_req), 0);
    chk_eq("R1 reset mem_req", 32'(mem_req), 0);
    chk_eq("R1 reset ctl_out", ctl_out, 0);

    // R3: request while disabled
    load(mk(2, 2, 2, 2, 3, 15, 2), 32'h1000_03FC, 32'h2000_03FC);
    request();
    cyc(4);
    chk_eq("R3 disabled request bus_req", 32'(bus_req), 0);
    chk_eq("R3 disabled request ctl_out", ctl_out, mk(2, 2, 2, 2, 3, 15, 2));

    // Main word copy, 16 items, release every 8
    gnt_pct = 60; rdy_pct = 70;
    run(mk(2, 2, 2, 2, 3, 15, 2), 32'h1000_03FC, 32'h2000_03FC);
    chk_eq("R9 enable cleared", 32'(en_status), 0);

    // R3: mode 0 while enabled
    enable();
    load(mk(2, 2, 2, 2, 3, 7, 0), 32'h1000_0100, 32'h2000_0100);
    request();
    cyc(4);
    chk_eq("R3 mode zero bus_req", 32'(bus_req), 0);

    // Bytes, fixed destination, release every item; R12 load during run
    load(mk(3, 0, 0, 0, 0, 4, 2), 32'h0000_0050, 32'h0000_0900);
    wr_cnt = 0;
    request();
    cyc(3);
    load(mk(1, 1, 1, 1, 5, 99, 2), 32'hDEAD_0000, 32'hBEEF_0000);
    chk_eq("R12 load ignored while busy", 32'(ctl_out[17:14]), 0);
    wait_done();
    chk_eq("R12 item count unchanged", wr_cnt, 5);

    // R10: enable set on the completion cycle, single halfword
    gnt_pct = 100; rdy_pct = 50;
    load(mk(1, 1, 1, 1, 0, 0, 2), 32'h0000_0402, 32'h0000_0802);
    enable();
    arm_end = 1; end_hit = 0;
    request();
    wait_done();
    chk_eq("R10 collision happened", 32'(end_hit), 1);
    chk_eq("R10 enable kept", 32'(en_status), 1);

    // R11: invalid size
    load(mk(2, 3, 2, 2, 3, 3, 2), 32'h1000_0010, 32'h2000_0010);
    request();
    cyc(3);
    chk_eq("R11 err raised", 32'(err), 1);
    chk_eq("R11 enable kept", 32'(en_status), 1);
    chk_eq("R11 no bus request", 32'(bus_req), 0);
    load(mk(2, 2, 2, 2, 3, 3, 2), 32'h1000_0010, 32'h2000_0010);
    chk_eq("R11 err cleared by load", 32'(err), 0);

    // Mixed patterns
    for (int t = 0; t < 6; t++) begin
      gnt_pct = 30 + 10 * t; rdy_pct = 40 + 10 * t;
      run(mk((t + 1) % 4, t % 3, t % 4, (t + 1) % 3, t % 4, 3 + 7 * t, 2),
          32'h4000_0800 + 32'(t * 64), 32'h5000_0C00 - 32'(t * 16));
    end

    // Largest block, release at 512
    gnt_pct = 100; rdy_pct = 100;
    run(mk(2, 2, 2, 2, 9, 1023, 2), 32'h6000_1000, 32'h7000_2000);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule